// File: doc/BRIEF.md
# Multi-Master Region Access Checker

This block sits beside a bus fabric and decides, for every access, whether the requesting master may touch the addressed location. A small set of region descriptors is supplied as static inputs from a register bank. Each descriptor holds a start address, an end address, a valid bit and a 32-bit rights word. For each access the checker finds every valid region that contains the address. It merges the rights those regions grant to the requesting master and returns a grant or a denial in the same cycle.

Masters are split into two classes. Privileged masters have separate user and supervisor rights and can be refused instruction fetches. The remaining masters carry only read and write enables and can never fetch. A denial is classified as no region hit, a single region hit or an overlap. It is written, with the faulting address, master number, attribute and access type, into a syndrome record owned by the slave port that carried the access. Each record has a sticky flag that software clears by writing one.

Top module: `region_access_checker`

## Requirements
- R1: Regions cover whole 32-byte blocks. Address bits 4:0 of the start are treated as zero, and address bits 4:0 of the end are treated as one.
- R2: A region whose valid bit is clear never hits. When the unit is enabled, an access that hits no region is denied.
- R3: Privileged master n (n below 4) uses bits 6n+5..6n of the rights word. Its user rights are bits 2:0 of that field: bit 2 allows read, bit 1 allows write and bit 0 allows fetch. Bit 5 of the field is not interpreted.
- R4: The supervisor rights of a privileged master are bits 4:3 of its field. Value 0 allows read, write and fetch. Value 1 allows read and fetch. Value 2 allows read and write. Value 3 applies the user rights.
- R5: Master n of 4 or above uses bit 24+2(n-4) as its write enable and bit 25+2(n-4) as its read enable. Its fetches are always denied, and the mode input does not affect it.
- R6: When several regions hit, the master's rights from all of them are ORed. The access is granted if any hitting region allows it.
- R7: While the global enable is low, every access is granted and no error is recorded.
- R8: A valid, denied access sets the error flag of its port on the next clock edge and records its address and master number.
- R9: The recorded control value is 0 when no region hit, 1 when exactly one region hit and 2 when two or more regions hit.
- R10: The recorded attribute is 0 for a user fetch, 1 for a user data access, 2 for a supervisor fetch and 3 for a supervisor data access. The recorded type is 1 for a write and 0 for a read or fetch. The access kind input uses 0 for read, 1 for write and 2 for fetch.
- R11: While a port's flag is set and not being cleared, later errors leave its record unchanged. Errors on one port never alter another port's flag or record.
- R12: Writing 1 to a port's clear bit drops its flag on the next edge. If a new error on that port arrives in the same cycle as the clear, the new error is recorded and the flag stays set.
- R13: After reset all flags and record fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global checking enable |
| rgn_valid | input | N_REGIONS | Per-region valid bits |
| rgn_start | input | N_REGIONS*ADDR_W | Packed region start addresses |
| rgn_end | input | N_REGIONS*ADDR_W | Packed region end addresses |
| rgn_rights | input | N_REGIONS*32 | Packed region rights words |
| acc_valid | input | 1 | Access strobe |
| acc_port | input | PORT_W | Slave port carrying the access |
| acc_addr | input | ADDR_W | Access address |
| acc_master | input | MID_W | Requesting master number |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | 1 supervisor mode, 0 user mode |
| err_clr | input | N_PORTS | Write-one-to-clear for each port flag |
| acc_grant | output | 1 | Access allowed (combinational) |
| err_flag | output | N_PORTS | Sticky error flags |
| err_addr | output | N_PORTS*ADDR_W | Recorded fault addresses |
| err_master | output | N_PORTS*MID_W | Recorded master numbers |
| err_attr | output | N_PORTS*2 | Recorded attributes |
| err_wr | output | N_PORTS | Recorded access types |
| err_ctrl | output | N_PORTS*2 | Recorded hit classification |

## Verification
The hardest case to reach is a denial that lands in an overlap of two regions. Each region alone must refuse the operation, yet their merged rights must still be checked, so that a partial grant in one region cannot mask the fault. The stimulus places two regions with complementary rights over a shared window and issues, in that window, an access that neither region permits. The same-cycle clear-and-capture race is reached by raising the clear bit in the very cycle that carries a fresh denial on an already flagged port.

// File: rtl/rac_pkg.sv
package rac_pkg;
   localparam int BLK_BITS    = 5;
   localparam int RIGHTS_W    = 32;
   localparam int PRIV_STRIDE = 6;
   localparam int NP_BASE     = 24;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_FETCH = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;

   typedef enum logic [1:0] {
      CTRL_NONE    = 2'd0,
      CTRL_SINGLE  = 2'd1,
      CTRL_OVERLAP = 2'd2
   } err_ctrl_e;
endpackage

// File: rtl/rgn_match.sv
module rgn_match
   import rac_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] start_a,
   input  logic [ADDR_W-1:0] end_a,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << BLK_BITS) - 1);

   logic [ADDR_W-1:0] lo_eff;
   logic [ADDR_W-1:0] hi_eff;

   initial begin
      if (ADDR_W <= BLK_BITS) $error("ADDR_W must exceed the block offset width");
   end

   always_comb begin
      lo_eff = start_a & ~BLK_MASK;
      hi_eff = end_a | BLK_MASK;
      hit    = valid && (addr >= lo_eff) && (addr <= hi_eff);
   end
endmodule

// File: rtl/rights_decode.sv
module rights_decode
   import rac_pkg::*;
#(
   parameter int N_MASTERS = 8,
   parameter int N_PRIV    = 4,
   parameter int MID_W     = 3
) (
   input  logic [RIGHTS_W-1:0] rights,
   input  logic [MID_W-1:0]    master,
   input  logic                super_m,
   output perm_t               perm
);
   initial begin
      if (N_PRIV * PRIV_STRIDE > NP_BASE) $error("too many privileged masters");
      if (NP_BASE + 2 * (N_MASTERS - N_PRIV) > RIGHTS_W) $error("too many plain masters");
      if ((1 << MID_W) < N_MASTERS) $error("MID_W too narrow");
   end

   logic [PRIV_STRIDE-1:0] fld;
   perm_t                  user_p;
   int                     idx;

   always_comb begin
      perm   = '0;
      fld    = '0;
      user_p = '0;
      idx    = 0;
      if (int'(master) < N_PRIV) begin
         idx    = PRIV_STRIDE * int'(master);
         fld    = rights[idx +: PRIV_STRIDE];
         user_p = '{r: fld[2], w: fld[1], x: fld[0]};
         if (!super_m) begin
            perm = user_p;
         end else begin
            case (fld[4:3])
               2'd0:    perm = '{r: 1'b1, w: 1'b1, x: 1'b1};
               2'd1:    perm = '{r: 1'b1, w: 1'b0, x: 1'b1};
               2'd2:    perm = '{r: 1'b1, w: 1'b1, x: 1'b0};
               default: perm = user_p;
            endcase
         end
      end else if (int'(master) < N_MASTERS) begin
         idx    = NP_BASE + 2 * (int'(master) - N_PRIV);
         perm.w = rights[idx];
         perm.r = rights[idx + 1];
         perm.x = 1'b0;
      end
   end
endmodule

// File: rtl/err_capture.sv
module err_capture
   import rac_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MID_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              clr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [MID_W-1:0]  in_master,
   input  logic [1:0]        in_attr,
   input  logic              in_wr,
   input  logic [1:0]        in_ctrl,
   output logic              flag,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [MID_W-1:0]  rec_master,
   output logic [1:0]        rec_attr,
   output logic              rec_wr,
   output logic [1:0]        rec_ctrl
);
   logic held;
   assign held = flag && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag       <= 1'b0;
         rec_addr   <= '0;
         rec_master <= '0;
         rec_attr   <= '0;
         rec_wr     <= 1'b0;
         rec_ctrl   <= '0;
      end else if (capture && !held) begin
         flag       <= 1'b1;
         rec_addr   <= in_addr;
         rec_master <= in_master;
         rec_attr   <= in_attr;
         rec_wr     <= in_wr;
         rec_ctrl   <= in_ctrl;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

   a_r8_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> flag);
   a_r11_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> (flag && $stable(rec_addr) && $stable(rec_ctrl) && $stable(rec_master)));
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !capture) |=> !flag);
   a_r9_ctrl_legal: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> (rec_ctrl != 2'd3));
endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
   import rac_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_REGIONS = 4,
   parameter int N_MASTERS = 8,
   parameter int N_PRIV    = 4,
   parameter int MID_W     = 3,
   parameter int N_PORTS   = 2,
   localparam int PORT_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          glb_en,
   input  logic [N_REGIONS-1:0]          rgn_valid,
   input  logic [N_REGIONS*ADDR_W-1:0]   rgn_start,
   input  logic [N_REGIONS*ADDR_W-1:0]   rgn_end,
   input  logic [N_REGIONS*RIGHTS_W-1:0] rgn_rights,
   input  logic                          acc_valid,
   input  logic [PORT_W-1:0]             acc_port,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [MID_W-1:0]              acc_master,
   input  logic [1:0]                    acc_kind,
   input  logic                          acc_super,
   input  logic [N_PORTS-1:0]            err_clr,
   output logic                          acc_grant,
   output logic [N_PORTS-1:0]            err_flag,
   output logic [N_PORTS*ADDR_W-1:0]     err_addr,
   output logic [N_PORTS*MID_W-1:0]      err_master,
   output logic [N_PORTS*2-1:0]          err_attr,
   output logic [N_PORTS-1:0]            err_wr,
   output logic [N_PORTS*2-1:0]          err_ctrl
);
   localparam int CNT_W = $clog2(N_REGIONS + 1);

   initial begin
      if (N_REGIONS < 1) $error("need at least one region");
      if (N_PORTS < 1) $error("need at least one port");
      if (N_PRIV > N_MASTERS) $error("N_PRIV exceeds N_MASTERS");
   end

   logic [N_REGIONS-1:0] hit_vec;
   perm_t                rgn_perm [N_REGIONS];
   perm_t                comb_perm;
   logic [CNT_W-1:0]     hit_cnt;
   logic                 allowed;
   logic                 deny;
   logic [1:0]           ctrl_val;
   logic [1:0]           attr_val;
   logic                 is_fetch;

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_rgn
      rgn_match #(.ADDR_W(ADDR_W)) u_match (
         .valid   (rgn_valid[r]),
         .start_a (rgn_start[r*ADDR_W +: ADDR_W]),
         .end_a   (rgn_end[r*ADDR_W +: ADDR_W]),
         .addr    (acc_addr),
         .hit     (hit_vec[r])
      );
      rights_decode #(.N_MASTERS(N_MASTERS), .N_PRIV(N_PRIV), .MID_W(MID_W)) u_dec (
         .rights  (rgn_rights[r*RIGHTS_W +: RIGHTS_W]),
         .master  (acc_master),
         .super_m (acc_super),
         .perm    (rgn_perm[r])
      );

      a_r2_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
         !rgn_valid[r] |-> !hit_vec[r]);
   end

   always_comb begin
      comb_perm = '0;
      hit_cnt   = '0;
      for (int r = 0; r < N_REGIONS; r++) begin
         if (hit_vec[r]) begin
            comb_perm = comb_perm | rgn_perm[r];
            hit_cnt   = hit_cnt + CNT_W'(1);
         end
      end
      case (acc_kind)
         KIND_READ:  allowed = comb_perm.r;
         KIND_WRITE: allowed = comb_perm.w;
         KIND_FETCH: allowed = comb_perm.x;
         default:    allowed = 1'b0;
      endcase
      if (hit_cnt == '0)              ctrl_val = CTRL_NONE;
      else if (hit_cnt == CNT_W'(1))  ctrl_val = CTRL_SINGLE;
      else                            ctrl_val = CTRL_OVERLAP;
      is_fetch = (acc_kind == KIND_FETCH);
      attr_val = {acc_super, !is_fetch};
   end

   assign acc_grant = !glb_en || allowed;
   assign deny      = acc_valid && !acc_grant;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic cap_p;
      assign cap_p = deny && (int'(acc_port) == p);

      err_capture #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_cap (
         .clk        (clk),
         .rst_n      (rst_n),
         .capture    (cap_p),
         .clr        (err_clr[p]),
         .in_addr    (acc_addr),
         .in_master  (acc_master),
         .in_attr    (attr_val),
         .in_wr      (acc_kind == KIND_WRITE),
         .in_ctrl    (ctrl_val),
         .flag       (err_flag[p]),
         .rec_addr   (err_addr[p*ADDR_W +: ADDR_W]),
         .rec_master (err_master[p*MID_W +: MID_W]),
         .rec_attr   (err_attr[p*2 +: 2]),
         .rec_wr     (err_wr[p]),
         .rec_ctrl   (err_ctrl[p*2 +: 2])
      );

      a_r8_denial_flags_port: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && !acc_grant && int'(acc_port) == p) |=> err_flag[p]);
   end

   a_r2_nohit_denied: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && hit_vec == '0) |-> !acc_grant);
   a_r5_plain_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && acc_kind == KIND_FETCH && int'(acc_master) >= N_PRIV) |-> !acc_grant);
endmodule

// File: tb/region_access_checker_test.sv
module region_access_checker_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        glb_en = 1'b1;
   logic [3:0]  rgn_valid;
   logic [127:0] rgn_start, rgn_end, rgn_rights;
   logic        acc_valid = 1'b0;
   logic [0:0]  acc_port = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [2:0]  acc_master = '0;
   logic [1:0]  acc_kind = '0;
   logic        acc_super = 1'b0;
   logic [1:0]  err_clr = '0;
   logic        acc_grant;
   logic [1:0]  err_flag;
   logic [63:0] err_addr;
   logic [5:0]  err_master;
   logic [3:0]  err_attr;
   logic [1:0]  err_wr;
   logic [3:0]  err_ctrl;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   region_access_checker uut (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rgn_valid(rgn_valid),
      .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_rights(rgn_rights),
      .acc_valid(acc_valid), .acc_port(acc_port), .acc_addr(acc_addr),
      .acc_master(acc_master), .acc_kind(acc_kind), .acc_super(acc_super),
      .err_clr(err_clr), .acc_grant(acc_grant), .err_flag(err_flag),
      .err_addr(err_addr), .err_master(err_master), .err_attr(err_attr),
      .err_wr(err_wr), .err_ctrl(err_ctrl)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [2:0]  mst;
      logic [1:0]  kind;
      logic        sup;
      logic        exp;
   } vec_t;

   // kind: 0 read, 1 write, 2 fetch
   localparam vec_t VECS [22] = '{
      '{32'h0000_1000, 3'd0, 2'd0, 1'b0, 1'b1},  // R3 user read
      '{32'h0000_1000, 3'd0, 2'd1, 1'b0, 1'b0},  // R3 user write refused
      '{32'h0000_1000, 3'd0, 2'd2, 1'b0, 1'b1},  // R3 user fetch
      '{32'h0000_1000, 3'd0, 2'd1, 1'b1, 1'b0},  // R4 sup=3 follows user
      '{32'h0000_1900, 3'd0, 2'd1, 1'b0, 1'b1},  // R6 OR gives write
      '{32'h0000_1900, 3'd0, 2'd1, 1'b1, 1'b0},  // R6 neither allows write
      '{32'h0000_1000, 3'd1, 2'd0, 1'b0, 1'b0},  // R3 user none
      '{32'h0000_1000, 3'd1, 2'd1, 1'b1, 1'b1},  // R4 sup=2 rw
      '{32'h0000_1000, 3'd1, 2'd2, 1'b1, 1'b0},  // R4 sup=2 no fetch
      '{32'h0000_1900, 3'd1, 2'd2, 1'b1, 1'b1},  // R4 sup=0 rwx
      '{32'h0000_2000, 3'd1, 2'd0, 1'b0, 1'b1},  // R3 user read only
      '{32'h0000_1000, 3'd4, 2'd0, 1'b0, 1'b1},  // R5 read bit
      '{32'h0000_1000, 3'd4, 2'd1, 1'b0, 1'b0},  // R5 no write
      '{32'h0000_1900, 3'd4, 2'd1, 1'b1, 1'b1},  // R5 write bit in other region
      '{32'h0000_1900, 3'd4, 2'd2, 1'b1, 1'b0},  // R5 no fetch
      '{32'h0000_1000, 3'd5, 2'd1, 1'b0, 1'b1},  // R5 write bit
      '{32'h0000_1000, 3'd5, 2'd0, 1'b1, 1'b0},  // R5 no read
      '{32'h0000_3000, 3'd2, 2'd1, 1'b0, 1'b1},  // R1 start rounded down
      '{32'h0000_301F, 3'd2, 2'd0, 1'b0, 1'b1},  // R1 end rounded up
      '{32'h0000_3020, 3'd2, 2'd0, 1'b0, 1'b0},  // R1 past block
      '{32'h0000_4000, 3'd0, 2'd0, 1'b0, 1'b0},  // R2 invalid region
      '{32'h0000_2FFF, 3'd0, 2'd0, 1'b0, 1'b0}   // R2 no region
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [0:0] prt, input logic [31:0] a, input logic [2:0] m,
                        input logic [1:0] k, input logic s);
      acc_valid  = 1'b1;
      acc_port   = prt;
      acc_addr   = a;
      acc_master = m;
      acc_kind   = k;
      acc_super  = s;
   endtask

   task automatic pulse_clr(input logic [1:0] c);
      @(negedge clk);
      acc_valid = 1'b0;
      err_clr   = c;
      @(negedge clk);
      err_clr   = 2'b00;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rgn_valid = 4'b0111;
      rgn_start = {32'h0000_4000, 32'h0000_3007, 32'h0000_1800, 32'h0000_1000};
      rgn_end   = {32'h0000_4FFF, 32'h0000_3010, 32'h0000_27FF, 32'h0000_1FFF};
      rgn_rights = {32'h0000_001F, 32'h0001_F000, 32'h0100_010A, 32'h0600_041D};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13 flags", 32'(err_flag), 32'h0);
      chk("R13 addr1", err_addr[63:32], 32'h0);
      chk("R13 ctrl", 32'(err_ctrl), 32'h0);

      for (int i = 0; i < 22; i++) begin
         @(negedge clk);
         drive(1'b0, VECS[i].addr, VECS[i].mst, VECS[i].kind, VECS[i].sup);
         #1;
         chk($sformatf("R1-6 vec%0d grant", i), 32'(acc_grant), 32'(VECS[i].exp));
      end
      @(negedge clk);
      acc_valid = 1'b0;

      // R12 clear both flags
      pulse_clr(2'b11);
      chk("R12 cleared", 32'(err_flag), 32'h0);

      // R8 R9 R10: overlap denial on port 1
      drive(1'b1, 32'h0000_1904, 3'd5, 2'd0, 1'b0);
      #1;
      chk("R6 overlap deny", 32'(acc_grant), 32'h0);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R8 flag1", 32'(err_flag[1]), 32'h1);
      chk("R8 addr1", err_addr[63:32], 32'h0000_1904);
      chk("R8 master1", 32'(err_master[5:3]), 32'd5);
      chk("R9 overlap ctrl", 32'(err_ctrl[3:2]), 32'd2);
      chk("R10 user data attr", 32'(err_attr[3:2]), 32'd1);
      chk("R10 read type", 32'(err_wr[1]), 32'd0);
      chk("R11 other port flag", 32'(err_flag[0]), 32'd0);

      // R11 sticky: later error does not overwrite
      @(negedge clk);
      drive(1'b1, 32'h0000_5000, 3'd0, 2'd1, 1'b1);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R11 addr kept", err_addr[63:32], 32'h0000_1904);
      chk("R11 ctrl kept", 32'(err_ctrl[3:2]), 32'd2);
      chk("R11 flag kept", 32'(err_flag[1]), 32'd1);

      // R12 clear then new capture
      pulse_clr(2'b10);
      chk("R12 flag1 cleared", 32'(err_flag[1]), 32'd0);
      drive(1'b1, 32'h0000_1000, 3'd1, 2'd2, 1'b1);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R9 single ctrl", 32'(err_ctrl[3:2]), 32'd1);
      chk("R10 sup fetch attr", 32'(err_attr[3:2]), 32'd2);
      chk("R8 master1 again", 32'(err_master[5:3]), 32'd1);

      // R10 supervisor write on port 0
      drive(1'b0, 32'h0000_1000, 3'd0, 2'd1, 1'b1);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R10 sup data attr", 32'(err_attr[1:0]), 32'd3);
      chk("R10 write type", 32'(err_wr[0]), 32'd1);
      chk("R8 addr0", err_addr[31:0], 32'h0000_1000);

      // R12 clear and new error in the same cycle
      drive(1'b1, 32'h0000_3020, 3'd2, 2'd0, 1'b0);
      err_clr = 2'b10;
      @(negedge clk);
      acc_valid = 1'b0;
      err_clr   = 2'b00;
      chk("R12 race flag", 32'(err_flag[1]), 32'd1);
      chk("R12 race addr", err_addr[63:32], 32'h0000_3020);
      chk("R9 no hit ctrl", 32'(err_ctrl[3:2]), 32'd0);

      // R7 global disable
      pulse_clr(2'b11);
      glb_en = 1'b0;
      drive(1'b0, 32'h0000_4000, 3'd0, 2'd1, 1'b0);
      #1;
      chk("R7 grant when off", 32'(acc_grant), 32'd1);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R7 no capture", 32'(err_flag), 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule